// File: doc/BRIEF.md
# Page-Mode DRAM Cycle Sequencer with Look-Ahead Hint

This block turns processor memory requests into page-mode DRAM strobe sequences. It drives RAS and CAS and a shared row/column address bus. With each request the processor also sends a one-bit look-ahead flag. The flag promises that the request after this one will go to the next higher address. The sequencer trusts that promise. It keeps the DRAM row open and serves the following request with a short column-only cycle of two ticks. Otherwise it closes the row and runs a long cycle of four ticks: a precharge tick, a row-address tick, then the column phase. While the long cycle does its extra work, a wait output holds the processor.

The sequencer never compares row addresses. It only checks whether the current column field is at its last value, because the next sequential address would then fall in a different row. A static-memory mode gives every access the same two-tick length with no wait. The mode is sampled with each request. Once a cycle's last tick has begun, a new request is accepted directly, so sequential bursts run with no idle tick between accesses.

Top module: `dram_seq_ctrl`

## Requirements
- R1: The first access after reset runs the long four-tick cycle, even if the access before the reset asked to keep its row open.
- R2: During reset and right after it, ras_n and cas_n are high and wait_o and done are low.
- R3: Long cycle, tick by tick. Tick 1: ras_n high, row on dram_addr, wait_o high. Tick 2: ras_n low, row on dram_addr, wait_o high. Tick 3: column on dram_addr, cas_n high. Tick 4: cas_n low, done high. cas_n is never low while ras_n is high.
- R4: An access runs the short cycle when the access before it had seq_next high, that access's column field was not all ones, and static_mode is low for both. The short cycle is two ticks, both with ras_n low and the column on dram_addr. Tick 1 has cas_n high. Tick 2 has cas_n low and done high.
- R5: If an access has seq_next low, the row is closed once that access ends, and the next access runs the long cycle.
- R6: If an access has seq_next high and its column field is all ones, the row is closed anyway, and the next access runs the long cycle.
- R7: With static_mode high at request time, the access takes two ticks and wait_o stays low. Tick 1 has ras_n low and the row on dram_addr. Tick 2 has cas_n low, the column on dram_addr and done high. The row is not left open afterwards.
- R8: A request present during the done tick is accepted at once. Its first tick follows the done tick directly.
- R9: wait_o is high only in the first two ticks of a long cycle. done is high for exactly one tick per access.
- R10: addr holds the row in its upper ROW_W bits and the column in its lower COL_W bits. Each field appears right-aligned on dram_addr.
- R11: While idle with the row left open, ras_n stays low. While idle with the row closed, ras_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller tick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Access request, held until the done tick |
| addr | input | ROW_W+COL_W | Access address, row field above column field |
| seq_next | input | 1 | Promise that the following access is at addr+1 |
| static_mode | input | 1 | Equal-length cycles for static memory |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| wait_o | output | 1 | Holds the processor during the extra ticks of a long cycle |
| done | output | 1 | Last tick of an access |

## Verification
The hardest case to reach from the ports is the hand-over inside the done tick. At that tick the outgoing access's look-ahead flag and last-column status decide the next cycle type, in the same edge that latches the new request. The stimulus holds req high through several accesses and changes the address and flag in the done tick. This runs a long cycle, a short cycle and a closing short cycle back to back. The bench then checks the done cadence and that ras_n stays low across the whole burst. Separate vectors approach the row edge at the last column with the flag high, switch static mode on and off between accesses, and apply reset while a row is held open.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_NPRE = 3'd1,
    ST_NROW = 3'd2,
    ST_COL  = 3'd3,
    ST_STRB = 3'd4,
    ST_SROW = 3'd5
  } cyc_state_e;
endpackage

// File: rtl/dsc_cycle_sel.sv
module dsc_cycle_sel #(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dsc_pkg::cyc_state_e   state_q,
  input  logic [COL_W-1:0]      col_q,
  input  logic                  hint_q,
  input  logic                  static_q,
  input  logic                  static_in,
  output logic                  use_short,
  output logic                  keep_open,
  output logic                  row_open_d
);
  import dsc_pkg::*;

  logic row_open_q;
  logic last_col;
  logic row_en;
  logic open_now;

  // next sequential address leaves the row when column is at its top value
  always_comb begin
    last_col   = &col_q;
    keep_open  = hint_q && !last_col && !static_q;
    row_en     = (state_q == ST_STRB);
    open_now   = row_en ? keep_open : row_open_q;
    row_open_d = open_now;
    use_short  = open_now && !static_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open_q <= 1'b0;
    end else if (row_en) begin
      row_open_q <= keep_open;
    end
  end

  // R6: a top-column access with the hint never leaves the row open
  p_cross_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en && last_col) |=> !row_open_q);
endmodule

// File: rtl/dsc_seq_fsm.sv
module dsc_seq_fsm #(
  parameter int AW = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [AW-1:0]         addr,
  input  logic                  hint,
  input  logic                  static_in,
  input  logic                  use_short,
  output dsc_pkg::cyc_state_e   state_q,
  output dsc_pkg::cyc_state_e   state_d,
  output logic                  accept,
  output logic [AW-1:0]         addr_q,
  output logic [AW-1:0]         addr_d,
  output logic                  hint_q,
  output logic                  static_q
);
  import dsc_pkg::*;

  cyc_state_e start_st;
  logic       hint_d;
  logic       static_d;

  always_comb begin
    accept = req && ((state_q == ST_IDLE) || (state_q == ST_STRB));
    if (static_in)      start_st = ST_SROW;
    else if (use_short) start_st = ST_COL;
    else                start_st = ST_NPRE;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = accept ? start_st : ST_IDLE;
      ST_NPRE: state_d = ST_NROW;
      ST_NROW: state_d = ST_COL;
      ST_COL:  state_d = ST_STRB;
      ST_SROW: state_d = ST_STRB;
      ST_STRB: state_d = accept ? start_st : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    addr_d   = accept ? addr      : addr_q;
    hint_d   = accept ? hint      : hint_q;
    static_d = accept ? static_in : static_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      hint_q   <= 1'b0;
      static_q <= 1'b0;
    end else if (accept) begin
      addr_q   <= addr_d;
      hint_q   <= hint_d;
      static_q <= static_d;
    end
  end

  // R3: precharge tick always followed by row tick
  p_pre_to_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NPRE) |=> (state_q == ST_NROW));
  // R7: a static request always begins with the static row tick
  p_static_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && static_in) |=> (state_q == ST_SROW));
endmodule

// File: rtl/dsc_strobe_gen.sv
module dsc_strobe_gen #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int MUX_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dsc_pkg::cyc_state_e     state_d,
  input  logic [ROW_W+COL_W-1:0]  addr_d,
  input  logic                    row_open_d,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic [MUX_W-1:0]        dram_addr,
  output logic                    wait_o,
  output logic                    done
);
  import dsc_pkg::*;

  localparam int AW = ROW_W + COL_W;

  logic [MUX_W-1:0] row_mux;
  logic [MUX_W-1:0] col_mux;
  logic             ras_n_d, cas_n_d, wait_d, done_d;
  logic [MUX_W-1:0] mux_d;

  always_comb begin
    row_mux = MUX_W'(addr_d[AW-1:COL_W]);
    col_mux = MUX_W'(addr_d[COL_W-1:0]);
    ras_n_d = 1'b0;
    cas_n_d = 1'b1;
    wait_d  = 1'b0;
    done_d  = 1'b0;
    mux_d   = row_mux;
    unique case (state_d)
      ST_IDLE: ras_n_d = !row_open_d;
      ST_NPRE: begin ras_n_d = 1'b1; wait_d = 1'b1; end
      ST_NROW: wait_d = 1'b1;
      ST_COL:  mux_d  = col_mux;
      ST_SROW: mux_d  = row_mux;
      ST_STRB: begin cas_n_d = 1'b0; done_d = 1'b1; mux_d = col_mux; end
      default: ras_n_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      wait_o    <= 1'b0;
      done      <= 1'b0;
      dram_addr <= '0;
    end else begin
      ras_n     <= ras_n_d;
      cas_n     <= cas_n_d;
      wait_o    <= wait_d;
      done      <= done_d;
      dram_addr <= mux_d;
    end
  end

  // R3: column strobe only inside an active row strobe
  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R9: done never lasts two ticks
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: no column strobe while the processor is held
  p_wait_no_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> cas_n);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  localparam int AW    = ROW_W + COL_W,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [AW-1:0]    addr,
  input  logic             seq_next,
  input  logic             static_mode,
  output logic             ras_n,
  output logic             cas_n,
  output logic [MUX_W-1:0] dram_addr,
  output logic             wait_o,
  output logic             done
);
  import dsc_pkg::*;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cyc_state_e       state_q, state_d;
  logic             accept, hint_q, static_q;
  logic [AW-1:0]    addr_q, addr_d;
  logic             use_short, keep_open, row_open_d;

  dsc_seq_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (req),
    .addr      (addr),
    .hint      (seq_next),
    .static_in (static_mode),
    .use_short (use_short),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .addr_q    (addr_q),
    .addr_d    (addr_d),
    .hint_q    (hint_q),
    .static_q  (static_q)
  );

  dsc_cycle_sel #(.COL_W(COL_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state_q    (state_q),
    .col_q      (addr_q[COL_W-1:0]),
    .hint_q     (hint_q),
    .static_q   (static_q),
    .static_in  (static_mode),
    .use_short  (use_short),
    .keep_open  (keep_open),
    .row_open_d (row_open_d)
  );

  dsc_strobe_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_strb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state_d    (state_d),
    .addr_d     (addr_d),
    .row_open_d (row_open_d),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .dram_addr  (dram_addr),
    .wait_o     (wait_o),
    .done       (done)
  );

  // R5: closing access handing over to a dynamic request opens a new row
  p_close_then_long_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_STRB) && accept && !keep_open && !static_mode)
      |=> (state_q == ST_NPRE));
endmodule

// File: tb/tb_dram_seq_ctrl.sv
module tb_dram_seq_ctrl;
  localparam int ROW_W = 10;
  localparam int COL_W = 10;
  localparam int AW    = ROW_W + COL_W;
  localparam int NV    = 10;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             hint;
    logic             stat;
    logic [2:0]       len;
    logic             open;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    {10'd5, 10'd10,  1'b1, 1'b0, 3'd4, 1'b1},
    {10'd5, 10'd11,  1'b1, 1'b0, 3'd2, 1'b1},
    {10'd5, 10'd12,  1'b0, 1'b0, 3'd2, 1'b0},
    {10'd5, 10'd13,  1'b1, 1'b0, 3'd4, 1'b1},
    {10'd5, 10'h3FF, 1'b1, 1'b0, 3'd2, 1'b0},
    {10'd6, 10'd0,   1'b1, 1'b0, 3'd4, 1'b1},
    {10'd6, 10'd1,   1'b1, 1'b1, 3'd2, 1'b0},
    {10'd6, 10'd2,   1'b1, 1'b0, 3'd4, 1'b1},
    {10'd6, 10'd3,   1'b0, 1'b0, 3'd2, 1'b0},
    {10'd7, 10'd20,  1'b0, 1'b0, 3'd4, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic seq_next = 1'b0;
  logic static_mode = 1'b0;
  logic ras_n, cas_n, wait_o, done;
  logic [9:0] dram_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .seq_next(seq_next),
    .static_mode(static_mode), .ras_n(ras_n), .cas_n(cas_n),
    .dram_addr(dram_addr), .wait_o(wait_o), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string len_tag(input int i);
    case (i)
      0: return "R1";
      3: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R7";
      9: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic run_access(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                            input logic hint, input logic stat, input int exp_len,
                            input logic exp_open, input string tag);
    int ticks = 0;
    int waits = 0;
    @(negedge clk);
    req = 1'b1; addr = {row, col}; seq_next = hint; static_mode = stat;
    @(negedge clk);
    req = 1'b0;
    // first tick
    ticks = 1;
    if (wait_o) waits++;
    if (exp_len == 4) begin
      chk(ras_n == 1'b1, "R3 precharge ras_n", ras_n, 1);
      chk(dram_addr == 10'(row), "R10 row on first tick", dram_addr, row);
    end else if (stat) begin
      chk(ras_n == 1'b0 && dram_addr == 10'(row), "R7 static row tick", dram_addr, row);
    end else begin
      chk(ras_n == 1'b0 && cas_n == 1'b1 && dram_addr == 10'(col),
          "R4 short column tick", dram_addr, col);
    end
    while (!done && ticks < 8) begin
      @(negedge clk);
      ticks++;
      if (wait_o) waits++;
    end
    chk(ticks == exp_len, tag, ticks, exp_len);
    chk(waits == ((exp_len == 4) ? 2 : 0), "R9 wait ticks", waits, (exp_len == 4) ? 2 : 0);
    chk(done && !cas_n && dram_addr == 10'(col), "R10 column at strobe", dram_addr, col);
    @(negedge clk);
    chk(ras_n == !exp_open, exp_open ? "R11 idle row held" : "R5 idle row closed",
        ras_n, !exp_open);
    chk(!done, "R9 done single tick", done, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(ras_n && cas_n && !wait_o && !done, "R2 in reset", {ras_n, cas_n, wait_o, done}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && !wait_o && !done, "R2 after reset", {ras_n, cas_n, wait_o, done}, 4'b1100);

    for (int i = 0; i < NV; i++) begin
      run_access(VECS[i].row, VECS[i].col, VECS[i].hint, VECS[i].stat,
                 int'(VECS[i].len), VECS[i].open, len_tag(i));
    end

    // R8: back-to-back burst, long then short then short
    @(negedge clk);
    req = 1'b1; addr = {10'd8, 10'd0}; seq_next = 1'b1; static_mode = 1'b0;
    for (int t = 1; t <= 9; t++) begin
      @(negedge clk);
      chk(done == (t == 4 || t == 6 || t == 8), "R8 done cadence", done, (t == 4 || t == 6 || t == 8));
      chk(ras_n == (t == 1 || t == 9), "R8 ras across burst", ras_n, (t == 1 || t == 9));
      if (t == 5) chk(dram_addr == 10'd1, "R8 second access column", dram_addr, 1);
      if (t == 7) chk(dram_addr == 10'd2, "R8 third access column", dram_addr, 2);
      if (t == 4) begin addr = {10'd8, 10'd1}; seq_next = 1'b1; end
      if (t == 6) begin addr = {10'd8, 10'd2}; seq_next = 1'b0; end
      if (t == 8) req = 1'b0;
    end

    // R1: row left open, then reset, next access must be long
    run_access(10'd9, 10'd0, 1'b1, 1'b0, 4, 1'b1, "R3 long before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ras_n && cas_n && !wait_o && !done, "R2 async reset", {ras_n, cas_n, wait_o, done}, 4'b1100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_access(10'd9, 10'd1, 1'b1, 1'b0, 4, 1'b1, "R1 long after reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule